// File: doc/BRIEF.md
# Byte-Multiplexer I/O Channel Scheduler

This block shares one byte-wide data path among eight device trunks. Software starts an operation on a trunk with a command that carries a memory address, a byte count and a direction. Each trunk that has an operation in progress raises a request when it has a byte to move. The scheduler grants one trunk per cycle, moves exactly one byte between that trunk and a single-cycle memory port, and advances that trunk's own address and count.

A start command can also ask for burst mode. A burst is refused unless no other trunk has an operation outstanding. Once it is accepted, the channel serves only the chosen trunk until its count runs out. A burst keeps its address, count and status in one shared channel register set and does not use the per-trunk subchannel state.

Whenever an operation ends, by running out of count or by a halt command, the scheduler raises a termination interrupt. The final address, the residual count and a halted flag appear in the shared channel registers, where software reads them before it acknowledges the interrupt.

Top module: `mux_io_channel`

## Requirements
- R1: Any of the eight trunks can have an operation in progress at the same time. A trunk is served only while it has an operation in progress and raises devReq. A requesting trunk with no operation gets no devAck.
- R2: At most one devAck bit is high in a cycle, and only for a trunk whose devReq is high. When cmdToMem=1 the trunk's byte on devDataIn is written to memAddr (memWe=1). When cmdToMem=0 the memory byte memRData is passed out on devDataOut in the same cycle as devAck.
- R3: Outside burst mode, grants rotate in round-robin order and the search starts at the trunk after the one served last. After reset the first grant goes to trunk 0.
- R4: Each transfer increments the trunk's address by one and decrements its count by one. The operation ends after exactly count bytes. A start with count 0 ends at once without moving any byte.
- R5: A start to a trunk that is still transferring, still has an unacknowledged termination, or arrives while a burst is active returns respCode 1 (busy). It changes nothing. respValid pulses in the cycle after each command.
- R6: A burst start (cmdBurst=1) while any trunk has an operation or termination outstanding returns respCode 2 (program check). It starts nothing.
- R7: While a burst is active, only the burst trunk receives devAck, even if other trunks request, until its count reaches zero.
- R8: A burst takes its address and count from the shared channel registers. At its end chanAddr holds the start address plus the bytes moved and chanCount holds 0.
- R9: A termination raises irq, which stays high until irqAck. While it is high, irqTrunk, chanAddr, chanCount and chanHalted describe the finished operation and hold steady.
- R10: When several terminations are waiting and no interrupt is shown, the lowest-numbered trunk is reported next.
- R11: A halt (cmdHalt=1) to a transferring or bursting trunk returns respCode 0. It ends the operation with chanHalted=1 and the residual count unchanged. A halt to an idle trunk returns respCode 3. An accepted start returns respCode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdHalt | input | 1 | 1 = halt, 0 = start |
| cmdBurst | input | 1 | Start in burst mode |
| cmdToMem | input | 1 | 1 = device to memory, 0 = memory to device |
| cmdTrunk | input | 3 | Trunk addressed by the command |
| cmdAddr | input | 16 | Start memory address |
| cmdCount | input | 16 | Byte count |
| respValid | output | 1 | Command response valid |
| respCode | output | 2 | 0 accept, 1 busy, 2 program check, 3 idle |
| devReq | input | 8 | Per-trunk byte request |
| devAck | output | 8 | Per-trunk byte acknowledge |
| devDataIn | input | 64 | Per-trunk byte from device, trunk t in bits 8t+7..8t |
| devDataOut | output | 8 | Byte to the acknowledged device |
| memReq | output | 1 | Memory access this cycle |
| memWe | output | 1 | Memory write |
| memAddr | output | 16 | Memory address |
| memWData | output | 8 | Memory write data |
| memRData | input | 8 | Memory read data, same cycle |
| irq | output | 1 | Termination interrupt |
| irqAck | input | 1 | Interrupt acknowledge |
| irqTrunk | output | 3 | Trunk being reported |
| chanAddr | output | 16 | Shared register: address |
| chanCount | output | 16 | Shared register: residual count |
| chanHalted | output | 1 | Shared register: ended by halt |

## Verification
The hardest state to reach is several terminations waiting behind an interrupt that is already shown. Reaching it is what shows that the lowest trunk is reported next and not the first trunk to finish. The bench starts seven trunks with counts that fall as the trunk number rises. The highest trunk therefore finishes first and takes the interrupt alone, and the others finish while it is held, so the next reports must run upward from trunk 0. The same window, with every trunk started and one left idle, is used to provoke the busy and program-check refusals. Burst lockout is checked with every trunk requesting throughout the burst.

// File: rtl/chan_pkg.sv
package chan_pkg;
  localparam int ByteW = 8;

  typedef enum logic [1:0] {
    RESP_ACCEPT    = 2'd0,
    RESP_BUSY      = 2'd1,
    RESP_PROGCHECK = 2'd2,
    RESP_IDLE      = 2'd3
  } respCodeT;

  // strobes from control to datapath
  typedef struct packed {
    logic svcSub;    // move a byte using subchannel state
    logic svcChan;   // move a byte using shared channel state
    logic loadSub;   // load subchannel from command
    logic loadChan;  // load shared registers from command (burst)
    logic copyChan;  // copy finished subchannel into shared registers
    logic haltSub;   // mark subchannel halted
    logic haltChan;  // mark burst halted
  } dpStrobeT;
endpackage

// File: rtl/mux_ctrl.sv
module mux_ctrl
  import chan_pkg::*;
#(
  parameter int NumTrunks = 8,
  parameter int TrunkW    = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic                 cmdHalt,
  input  logic                 cmdBurst,
  input  logic                 cmdCountZero,
  input  logic [TrunkW-1:0]    cmdTrunk,
  input  logic [NumTrunks-1:0] devReq,
  input  logic                 irqAck,
  input  logic                 lastByte,
  output dpStrobeT             stb,
  output logic [TrunkW-1:0]    svcTrunk,
  output logic [TrunkW-1:0]    reportTrunk,
  output logic [TrunkW-1:0]    ownerTrunk,
  output logic [NumTrunks-1:0] devAck,
  output logic                 memReq,
  output logic                 irq,
  output logic                 respValid,
  output respCodeT             respCode
);
  logic [NumTrunks-1:0] active, pending, activeNext, pendingNext;
  logic [NumTrunks-1:0] cmdSel, ownerSel, haltMask, eligible;
  logic burstOn, irqOn, svc, copyReq, burstEnd;
  logic acceptSub, acceptBurst, haltSub, haltChan;
  logic [TrunkW-1:0] rrPtr, owner, grant, lowest;
  respCodeT respNext;

  assign cmdSel   = NumTrunks'(1) << cmdTrunk;
  assign ownerSel = NumTrunks'(1) << owner;
  assign haltMask = (cmdValid && cmdHalt) ? cmdSel : '0;
  assign eligible = devReq & ~haltMask & (burstOn ? ownerSel : active);

  // round-robin: smallest offset after the last served trunk wins
  always_comb begin
    svc   = 1'b0;
    grant = rrPtr;
    for (int off = NumTrunks; off >= 1; off--) begin
      if (eligible[(int'(rrPtr) + off) % NumTrunks]) begin
        svc   = 1'b1;
        grant = TrunkW'((int'(rrPtr) + off) % NumTrunks);
      end
    end
  end

  always_comb begin
    lowest = '0;
    for (int t = NumTrunks - 1; t >= 0; t--) begin
      if (pending[t]) lowest = TrunkW'(t);
    end
  end

  // command decode
  always_comb begin
    respNext    = RESP_ACCEPT;
    acceptSub   = 1'b0;
    acceptBurst = 1'b0;
    haltSub     = 1'b0;
    haltChan    = 1'b0;
    if (cmdValid) begin
      if (!cmdHalt) begin
        if (burstOn || active[cmdTrunk] || pending[cmdTrunk]) respNext = RESP_BUSY;
        else if (cmdBurst && |(active | pending))            respNext = RESP_PROGCHECK;
        else begin
          acceptBurst = cmdBurst;
          acceptSub   = !cmdBurst;
        end
      end else begin
        if (burstOn && cmdTrunk == owner) haltChan = 1'b1;
        else if (active[cmdTrunk])        haltSub  = 1'b1;
        else                              respNext = RESP_IDLE;
      end
    end
  end

  assign burstEnd = (burstOn && svc && lastByte) || haltChan;
  assign copyReq  = !irqOn && !burstOn && (|pending);

  always_comb begin
    activeNext  = active;
    pendingNext = pending;
    if (irqOn && irqAck) pendingNext[owner] = 1'b0;
    if (svc && !burstOn && lastByte) begin
      activeNext[grant]  = 1'b0;
      pendingNext[grant] = 1'b1;
    end
    if (haltSub) begin
      activeNext[cmdTrunk]  = 1'b0;
      pendingNext[cmdTrunk] = 1'b1;
    end
    if (acceptSub && !cmdCountZero) activeNext[cmdTrunk] = 1'b1;
    if ((acceptSub || acceptBurst) && cmdCountZero) pendingNext[cmdTrunk] = 1'b1;
    if (burstEnd) pendingNext[owner] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active    <= '0;
      pending   <= '0;
      burstOn   <= 1'b0;
      irqOn     <= 1'b0;
      owner     <= '0;
      rrPtr     <= TrunkW'(NumTrunks - 1);
      respValid <= 1'b0;
      respCode  <= RESP_ACCEPT;
    end else begin
      active    <= activeNext;
      pending   <= pendingNext;
      respValid <= cmdValid;
      respCode  <= respNext;
      if (svc) rrPtr <= grant;
      if (irqOn && irqAck) irqOn <= 1'b0;
      else if (copyReq || burstEnd || (acceptBurst && cmdCountZero)) irqOn <= 1'b1;
      if (acceptBurst)  owner <= cmdTrunk;
      else if (copyReq) owner <= lowest;
      if (acceptBurst)   burstOn <= !cmdCountZero;
      else if (burstEnd) burstOn <= 1'b0;
    end
  end

  assign stb = '{svcSub: svc && !burstOn, svcChan: svc && burstOn, loadSub: acceptSub,
                 loadChan: acceptBurst, copyChan: copyReq, haltSub: haltSub, haltChan: haltChan};
  assign svcTrunk    = grant;
  assign reportTrunk = lowest;
  assign ownerTrunk  = owner;
  assign devAck      = svc ? (NumTrunks'(1) << grant) : '0;
  assign memReq      = svc;
  assign irq         = irqOn;
endmodule

// File: rtl/mux_datapath.sv
module mux_datapath
  import chan_pkg::*;
#(
  parameter int NumTrunks = 8,
  parameter int TrunkW    = 3,
  parameter int AddrW     = 16,
  parameter int CountW    = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpStrobeT                   stb,
  input  logic [TrunkW-1:0]          svcTrunk,
  input  logic [TrunkW-1:0]          reportTrunk,
  input  logic [TrunkW-1:0]          cmdTrunk,
  input  logic [AddrW-1:0]           cmdAddr,
  input  logic [CountW-1:0]          cmdCount,
  input  logic                       cmdToMem,
  input  logic [NumTrunks*ByteW-1:0] devDataIn,
  input  logic [ByteW-1:0]           memRData,
  output logic [AddrW-1:0]           memAddr,
  output logic                       memWe,
  output logic [ByteW-1:0]           memWData,
  output logic [ByteW-1:0]           devDataOut,
  output logic                       lastByte,
  output logic [AddrW-1:0]           chanAddr,
  output logic [CountW-1:0]          chanCount,
  output logic                       chanHalted
);
  logic [AddrW-1:0]  subAddr   [NumTrunks];
  logic [CountW-1:0] subCount  [NumTrunks];
  logic              subToMem  [NumTrunks];
  logic              subHalted [NumTrunks];
  logic              chanToMem;

  for (genvar g = 0; g < NumTrunks; g++) begin : gSub
    always_ff @(posedge clk) begin
      if (!rstN) begin
        subAddr[g]   <= '0;
        subCount[g]  <= '0;
        subToMem[g]  <= 1'b0;
        subHalted[g] <= 1'b0;
      end else if (stb.loadSub && cmdTrunk == TrunkW'(g)) begin
        subAddr[g]   <= cmdAddr;
        subCount[g]  <= cmdCount;
        subToMem[g]  <= cmdToMem;
        subHalted[g] <= 1'b0;
      end else begin
        if (stb.svcSub && svcTrunk == TrunkW'(g)) begin
          subAddr[g]  <= subAddr[g] + AddrW'(1);
          subCount[g] <= subCount[g] - CountW'(1);
        end
        if (stb.haltSub && cmdTrunk == TrunkW'(g)) subHalted[g] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanAddr   <= '0;
      chanCount  <= '0;
      chanToMem  <= 1'b0;
      chanHalted <= 1'b0;
    end else if (stb.loadChan) begin
      chanAddr   <= cmdAddr;
      chanCount  <= cmdCount;
      chanToMem  <= cmdToMem;
      chanHalted <= 1'b0;
    end else if (stb.copyChan) begin
      chanAddr   <= subAddr[reportTrunk];
      chanCount  <= subCount[reportTrunk];
      chanToMem  <= subToMem[reportTrunk];
      chanHalted <= subHalted[reportTrunk];
    end else begin
      if (stb.svcChan) begin
        chanAddr  <= chanAddr + AddrW'(1);
        chanCount <= chanCount - CountW'(1);
      end
      if (stb.haltChan) chanHalted <= 1'b1;
    end
  end

  assign memAddr    = stb.svcChan ? chanAddr : subAddr[svcTrunk];
  assign memWe      = (stb.svcChan && chanToMem) || (stb.svcSub && subToMem[svcTrunk]);
  assign memWData   = devDataIn[int'(svcTrunk)*ByteW +: ByteW];
  assign devDataOut = memRData;
  assign lastByte   = (stb.svcChan ? chanCount : subCount[svcTrunk]) == CountW'(1);
endmodule

// File: rtl/mux_io_channel.sv
module mux_io_channel
  import chan_pkg::*;
#(
  parameter int NumTrunks = 8,
  parameter int AddrW     = 16,
  parameter int CountW    = 16,
  localparam int TrunkW   = $clog2(NumTrunks)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cmdValid,
  input  logic                       cmdHalt,
  input  logic                       cmdBurst,
  input  logic                       cmdToMem,
  input  logic [TrunkW-1:0]          cmdTrunk,
  input  logic [AddrW-1:0]           cmdAddr,
  input  logic [CountW-1:0]          cmdCount,
  output logic                       respValid,
  output logic [1:0]                 respCode,
  input  logic [NumTrunks-1:0]       devReq,
  output logic [NumTrunks-1:0]       devAck,
  input  logic [NumTrunks*ByteW-1:0] devDataIn,
  output logic [ByteW-1:0]           devDataOut,
  output logic                       memReq,
  output logic                       memWe,
  output logic [AddrW-1:0]           memAddr,
  output logic [ByteW-1:0]           memWData,
  input  logic [ByteW-1:0]           memRData,
  output logic                       irq,
  input  logic                       irqAck,
  output logic [TrunkW-1:0]          irqTrunk,
  output logic [AddrW-1:0]           chanAddr,
  output logic [CountW-1:0]          chanCount,
  output logic                       chanHalted
);
  dpStrobeT          stb;
  logic [TrunkW-1:0] svcTrunk, reportTrunk;
  logic              lastByte;
  respCodeT          respEnum;

  assign respCode = respEnum;

  mux_ctrl #(.NumTrunks(NumTrunks), .TrunkW(TrunkW)) i_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdHalt(cmdHalt), .cmdBurst(cmdBurst),
    .cmdCountZero(cmdCount == '0), .cmdTrunk(cmdTrunk), .devReq(devReq), .irqAck(irqAck),
    .lastByte(lastByte), .stb(stb), .svcTrunk(svcTrunk), .reportTrunk(reportTrunk),
    .ownerTrunk(irqTrunk), .devAck(devAck), .memReq(memReq), .irq(irq),
    .respValid(respValid), .respCode(respEnum)
  );

  mux_datapath #(.NumTrunks(NumTrunks), .TrunkW(TrunkW), .AddrW(AddrW), .CountW(CountW)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .svcTrunk(svcTrunk), .reportTrunk(reportTrunk),
    .cmdTrunk(cmdTrunk), .cmdAddr(cmdAddr), .cmdCount(cmdCount), .cmdToMem(cmdToMem),
    .devDataIn(devDataIn), .memRData(memRData), .memAddr(memAddr), .memWe(memWe),
    .memWData(memWData), .devDataOut(devDataOut), .lastByte(lastByte),
    .chanAddr(chanAddr), .chanCount(chanCount), .chanHalted(chanHalted)
  );
endmodule

// File: rtl/mux_io_channel_chk.sv
module mux_io_channel_chk #(
  parameter int NumTrunks = 8,
  parameter int AddrW     = 16,
  parameter int CountW    = 16,
  parameter int TrunkW    = 3
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cmdValid,
  input logic                 respValid,
  input logic [NumTrunks-1:0] devReq,
  input logic [NumTrunks-1:0] devAck,
  input logic                 memReq,
  input logic                 memWe,
  input logic                 irq,
  input logic                 irqAck,
  input logic [TrunkW-1:0]    irqTrunk,
  input logic [AddrW-1:0]     chanAddr,
  input logic [CountW-1:0]    chanCount,
  input logic                 chanHalted
);
  assert_ack_onehot_R2: assert property (@(posedge clk) disable iff (!rstN) $onehot0(devAck));

  assert_ack_needs_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    (devAck & ~devReq) == '0);

  assert_mem_with_ack_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReq == (devAck != '0));

  assert_write_in_access_R2: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memReq);

  assert_irq_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !irqAck) |=> (irq && $stable(irqTrunk) && $stable(chanAddr)
                          && $stable(chanCount) && $stable(chanHalted)));

  assert_resp_after_cmd_R5: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $past(cmdValid));
endmodule

bind mux_io_channel mux_io_channel_chk #(
  .NumTrunks(NumTrunks), .AddrW(AddrW), .CountW(CountW), .TrunkW(TrunkW)
) i_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .respValid(respValid), .devReq(devReq),
  .devAck(devAck), .memReq(memReq), .memWe(memWe), .irq(irq), .irqAck(irqAck),
  .irqTrunk(irqTrunk), .chanAddr(chanAddr), .chanCount(chanCount), .chanHalted(chanHalted)
);

// File: tb/test_mux_io_channel.sv
module test_mux_io_channel;
  localparam int N = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdValid = 0, cmdHalt = 0, cmdBurst = 0, cmdToMem = 0;
  logic [2:0] cmdTrunk = '0;
  logic [15:0] cmdAddr = '0, cmdCount = '0;
  logic respValid;
  logic [1:0] respCode;
  logic [N-1:0] devReq = '0, devAck;
  logic [N*8-1:0] devDataIn;
  logic [7:0] devDataOut, memWData, memRData;
  logic memReq, memWe, irq, chanHalted;
  logic irqAck = 1'b0;
  logic [15:0] memAddr, chanAddr, chanCount;
  logic [2:0] irqTrunk;

  int checks = 0, errors = 0;
  logic [7:0] mem [1024];
  int ackLog [256];
  int ackLen = 0;
  int ackCnt [N];
  logic [7:0] rdLog [N][64];

  always #2 clk = ~clk;

  mux_io_channel i_mux_io_channel (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdHalt(cmdHalt), .cmdBurst(cmdBurst),
    .cmdToMem(cmdToMem), .cmdTrunk(cmdTrunk), .cmdAddr(cmdAddr), .cmdCount(cmdCount),
    .respValid(respValid), .respCode(respCode), .devReq(devReq), .devAck(devAck),
    .devDataIn(devDataIn), .devDataOut(devDataOut), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWData(memWData), .memRData(memRData), .irq(irq),
    .irqAck(irqAck), .irqTrunk(irqTrunk), .chanAddr(chanAddr), .chanCount(chanCount),
    .chanHalted(chanHalted)
  );

  // device bytes: trunk t sends t*32 + bytes already sent
  always_comb begin
    for (int t = 0; t < N; t++) devDataIn[t*8 +: 8] = 8'(t*32 + ackCnt[t]);
  end
  assign memRData = mem[memAddr[9:0]];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 1024; i++) mem[i] <= 8'(i) ^ 8'hA5;
      for (int t = 0; t < N; t++) ackCnt[t] <= 0;
      ackLen <= 0;
    end else begin
      if (memReq && memWe) mem[memAddr[9:0]] <= memWData;
      for (int t = 0; t < N; t++) begin
        if (devAck[t]) begin
          ackLog[ackLen] <= t;
          if (ackCnt[t] < 64) rdLog[t][ackCnt[t]] <= devDataOut;
          ackCnt[t] <= ackCnt[t] + 1;
          ackLen <= ackLen + 1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doCmd(input bit halt, input bit burst, input bit toMem, input int trunk,
                       input int addr, input int count, input int expResp, input string req);
    @(negedge clk);
    cmdValid = 1; cmdHalt = halt; cmdBurst = burst; cmdToMem = toMem;
    cmdTrunk = 3'(trunk); cmdAddr = 16'(addr); cmdCount = 16'(count);
    @(negedge clk);
    check(respValid == 1'b1, {req, " respValid"}, int'(respValid), 1);
    check(int'(respCode) == expResp, {req, " respCode"}, int'(respCode), expResp);
    cmdValid = 0;
  endtask

  task automatic serviceIrq(input int trunk, input int addr, input int count, input bit halted,
                            input string req);
    int waitCyc = 0;
    while (!irq && waitCyc < 3000) begin
      @(negedge clk);
      waitCyc++;
    end
    check(irq == 1'b1, {req, " irq raised"}, int'(irq), 1);
    check(int'(irqTrunk) == trunk, {req, " irqTrunk"}, int'(irqTrunk), trunk);
    check(int'(chanAddr) == addr, {req, " chanAddr"}, int'(chanAddr), addr);
    check(int'(chanCount) == count, {req, " chanCount"}, int'(chanCount), count);
    check(chanHalted == halted, {req, " chanHalted"}, int'(chanHalted), int'(halted));
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int rem [N];
    int total, start, ptr, pick, base5;
    int irqOrder [7];
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    check(irq == 1'b0, "R9 reset irq", int'(irq), 0);
    check(devAck == '0, "R2 reset devAck", int'(devAck), 0);
    check(memReq == 1'b0, "R2 reset memReq", int'(memReq), 0);
    check(respValid == 1'b0, "R5 reset respValid", int'(respValid), 0);

    // time-shared: trunks 0..6, count 9-t, even trunks write memory, odd read
    total = 0;
    for (int t = 0; t < 7; t++) begin
      doCmd(0, 0, (t % 2) == 0, t, t*64, 9 - t, 0, "R11 start accept");
      rem[t] = 9 - t;
      total += 9 - t;
    end
    rem[7] = 0;
    doCmd(0, 0, 1, 3, 999, 1, 1, "R5 busy start");
    doCmd(0, 1, 1, 7, 900, 4, 2, "R6 burst refused");
    start = ackLen;
    @(negedge clk);
    devReq = 8'hFF;
    for (int i = 0; i < 400 && ackLen < start + total; i++) @(negedge clk);
    repeat (5) @(negedge clk);
    check(ackLen - start == total, "R4 total bytes", ackLen - start, total);
    check(ackCnt[7] == 0, "R1 idle trunk not served", ackCnt[7], 0);
    check(ackCnt[3] == 6, "R5 busy start left count", ackCnt[3], 6);
    // round-robin model
    ptr = N - 1;
    for (int k = 0; k < total; k++) begin
      pick = -1;
      for (int off = 1; off <= N && pick < 0; off++)
        if (rem[(ptr + off) % N] > 0) pick = (ptr + off) % N;
      rem[pick]--;
      ptr = pick;
      check(ackLog[start + k] == pick, "R3 grant order", ackLog[start + k], pick);
    end
    for (int t = 0; t < 7; t++) begin
      for (int i = 0; i < 9 - t; i++) begin
        if (t % 2 == 0)
          check(mem[t*64 + i] == 8'(t*32 + i), "R2 byte to memory", int'(mem[t*64 + i]), (t*32 + i) % 256);
        else
          check(rdLog[t][i] == (8'(t*64 + i) ^ 8'hA5), "R2 byte to device", int'(rdLog[t][i]),
                int'(8'(t*64 + i) ^ 8'hA5));
      end
    end
    // trunk 6 ends first alone; rest reported lowest first
    irqOrder = '{6, 0, 1, 2, 3, 4, 5};
    for (int k = 0; k < 7; k++)
      serviceIrq(irqOrder[k], irqOrder[k]*64 + 9 - irqOrder[k], 0, 0, "R10 R9 report");

    // burst on trunk 5 while all trunks request
    base5 = ackCnt[5];
    start = ackLen;
    doCmd(0, 1, 1, 5, 600, 20, 0, "R7 burst accept");
    doCmd(0, 0, 1, 1, 100, 3, 1, "R7 start during burst busy");
    serviceIrq(5, 620, 0, 0, "R8 burst end");
    check(ackLen - start == 20, "R7 burst bytes", ackLen - start, 20);
    for (int k = start; k < ackLen; k++)
      check(ackLog[k] == 5, "R7 only burst trunk", ackLog[k], 5);
    for (int i = 0; i < 20; i++)
      check(mem[600 + i] == 8'(160 + base5 + i), "R8 burst data", int'(mem[600 + i]), (160 + base5 + i) % 256);

    // halts
    devReq = '0;
    doCmd(0, 0, 1, 4, 300, 100, 0, "R11 start for halt");
    doCmd(1, 0, 0, 4, 0, 0, 0, "R11 halt active");
    serviceIrq(4, 300, 100, 1, "R11 halted report");
    doCmd(1, 0, 0, 2, 0, 0, 3, "R11 halt idle");
    doCmd(0, 1, 0, 6, 700, 50, 0, "R11 burst for halt");
    doCmd(1, 0, 0, 6, 0, 0, 0, "R11 halt burst");
    serviceIrq(6, 700, 50, 1, "R11 halted burst report");

    // zero counts
    start = ackLen;
    doCmd(0, 0, 1, 2, 55, 0, 0, "R4 zero count start");
    serviceIrq(2, 55, 0, 0, "R4 zero count report");
    doCmd(0, 1, 1, 3, 77, 0, 0, "R4 zero count burst");
    serviceIrq(3, 77, 0, 0, "R4 zero burst report");
    check(ackLen == start, "R4 zero count moves nothing", ackLen - start, 0);

    // sweep bursts over every trunk and small counts
    devReq = 8'hFF;
    for (int t = 0; t < N; t++) begin
      for (int c = 1; c <= 3; c++) begin
        start = ackLen;
        doCmd(0, 1, 0, t, 800 + t*8, c, 0, "R7 sweep accept");
        serviceIrq(t, 800 + t*8 + c, 0, 0, "R8 sweep report");
        check(ackLen - start == c, "R4 sweep bytes", ackLen - start, c);
        for (int k = start; k < ackLen; k++)
          check(ackLog[k] == t, "R7 sweep trunk", ackLog[k], t);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule